// File: doc/BRIEF.md
# Touch Channel Detection Processor

This block turns one capacitive key's stream of acquisition counts into a touched/untouched decision and a key output level. Each valid count is compared with a per-channel reference. A touch is declared once the count has stood a fixed margin above that reference for several samples in a row. It is released, with hysteresis, when the margin collapses. While the key is idle, the reference follows slow environmental drift. It moves faster downward than upward, and it does not move at all while a touch is held or while an external arbiter suppresses a strong signal.

A millisecond tick drives two things: the drift rate limits and a stuck-key timer. When that timer expires, or when a recalibration is requested, the channel is recalibrated: the next valid count becomes the new reference. A two-bit select chooses between level (DC) and toggle output behaviour and between three stuck-key limits. A drive-type bit picks the output polarity. An arbiter shared between channels drives the hold input, so that only the dominant key may newly confirm a touch.

Top module: `touch_chan_proc`

## Requirements
- R1: Under reset, and on the first cycle after it, `detected` is 0, `delta` is 0 and `key_out` sits at its inactive level (equal to `drv_od`).
- R2: After a reset or a recalibration, the first valid sample loads the reference and reports `delta` 0. Every later valid sample reports `delta` = sample − reference (signed, saturated), one cycle after the strobe.
- R3: A touch is declared only on the third consecutive valid sample with delta ≥ 6. Any idle sample with delta < 6 restarts the run.
- R4: A declared touch persists while delta ≥ 4. It releases on the first valid sample with delta < 4.
- R5: While `hold_in` is 1, no new touch is declared. Hits still accumulate, so the first hit after `hold_in` falls confirms at once if three or more hits are already counted.
- R6: While idle, the reference rises by 1 toward a higher sample only if at least UP_MS ticks have passed since calibration or its last upward step.
- R7: While idle, the reference falls by 1 toward a lower sample only if at least DN_MS ticks have passed since calibration or its last downward step.
- R8: The reference does not move while a touch is declared, or while `hold_in` is 1 and delta ≥ 6.
- R9: The `tmo_sel` encoding is 00 = DC with no limit, 01 = DC with SHORT_MS, 10 = DC with LONG_MS, 11 = toggle with SHORT_MS. A touch that has been held for the chosen limit in ticks is cleared and the channel recalibrates.
- R10: In DC mode the active state equals `detected`. After a timeout it stays inactive until a new touch is declared.
- R11: In toggle mode each newly declared touch inverts the active state. A release or a timeout leaves it unchanged.
- R12: `key_out` = active state XOR `drv_od` (0 = active-high push-pull, 1 = active-low open drain), one cycle after the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Acquisition count strobe |
| smp_cnt | input | CNT_W | Acquisition count |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| recal_req | input | 1 | Force recalibration |
| tmo_sel | input | 2 | Output mode / stuck-key limit select |
| drv_od | input | 1 | Output polarity select |
| hold_in | input | 1 | Arbiter suppress: block new touch, freeze drift on strong signal |
| detected | output | 1 | Touch declared |
| delta | output | CNT_W | Signed sample minus reference |
| key_out | output | 1 | Key output level |

## Verification
The hardest state to reach from the ports is a drift step that is isolated from everything else. Both age counters run on every tick, so a test of one direction would normally be tainted by the other counter, which is already saturated. The stimulus therefore recalibrates before each drift test and then places a valid sample one tick short of the limit and again exactly at it. Timeouts are reached the same way, with the limits shrunk to tens of ticks, and expiry is probed one tick before and at the boundary for each select code.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef struct packed {
    logic dc_mode;
    logic no_limit;
    logic long_lim;
  } tcp_cfg_t;

  function automatic tcp_cfg_t tcp_decode_sel(input logic [1:0] sel);
    tcp_cfg_t c;
    case (sel)
      2'b00:   c = '{dc_mode: 1'b1, no_limit: 1'b1, long_lim: 1'b0};
      2'b01:   c = '{dc_mode: 1'b1, no_limit: 1'b0, long_lim: 1'b0};
      2'b10:   c = '{dc_mode: 1'b1, no_limit: 1'b0, long_lim: 1'b1};
      default: c = '{dc_mode: 1'b0, no_limit: 1'b0, long_lim: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tcp_ref_track.sv
module tcp_ref_track #(
  parameter int CNT_W = 16,
  parameter int UP_MS = 990,
  parameter int DN_MS = 231
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic [CNT_W-1:0]        smp_cnt,
  input  logic signed [CNT_W:0]   diff,
  input  logic                    ms_tick,
  input  logic                    recal_any,
  input  logic                    freeze,
  output logic [CNT_W-1:0]        ref_q,
  output logic                    cal_pend_q
);
  localparam int UP_W = $clog2(UP_MS + 1);
  localparam int DN_W = $clog2(DN_MS + 1);
  localparam logic [UP_W-1:0] UP_LIM = UP_W'(UP_MS);
  localparam logic [DN_W-1:0] DN_LIM = DN_W'(DN_MS);

  logic [UP_W-1:0] up_age_q;
  logic [DN_W-1:0] dn_age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q      <= '0;
      cal_pend_q <= 1'b1;
      up_age_q   <= '0;
      dn_age_q   <= '0;
    end else if (recal_any) begin
      cal_pend_q <= 1'b1;
      up_age_q   <= '0;
      dn_age_q   <= '0;
    end else begin
      if (ms_tick) begin
        if (up_age_q < UP_LIM) up_age_q <= up_age_q + 1'b1;
        if (dn_age_q < DN_LIM) dn_age_q <= dn_age_q + 1'b1;
      end
      if (smp_vld) begin
        if (cal_pend_q) begin
          ref_q      <= smp_cnt;
          cal_pend_q <= 1'b0;
          up_age_q   <= '0;
          dn_age_q   <= '0;
        end else if (!freeze) begin
          if (diff > 0 && up_age_q >= UP_LIM) begin
            ref_q    <= ref_q + 1'b1;
            up_age_q <= '0;
          end else if (diff < 0 && dn_age_q >= DN_LIM) begin
            ref_q    <= ref_q - 1'b1;
            dn_age_q <= '0;
          end
        end
      end
    end
  end

  p_cal_load_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && cal_pend_q && !recal_any) |=> (ref_q == $past(smp_cnt)));

  p_up_rate_r6: assert property (@(posedge clk) disable iff (rst)
    (!cal_pend_q && up_age_q < UP_LIM) |=> (ref_q != $past(ref_q) + CNT_W'(1)));

  p_dn_rate_r7: assert property (@(posedge clk) disable iff (rst)
    (!cal_pend_q && dn_age_q < DN_LIM) |=> (ref_q != $past(ref_q) - CNT_W'(1)));

  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (!cal_pend_q && freeze) |=> $stable(ref_q));

endmodule

// File: rtl/tcp_detect.sv
module tcp_detect #(
  parameter int CNT_W   = 16,
  parameter int THRESH  = 6,
  parameter int HYST    = 2,
  parameter int CONFIRM = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic                    cal_pend,
  input  logic signed [CNT_W:0]   diff,
  input  logic                    hold_in,
  input  logic                    recal_any,
  output logic                    det_q,
  output logic signed [CNT_W-1:0] delta_q
);
  localparam int INT_W = $clog2(CONFIRM + 1);
  localparam logic [INT_W-1:0] INT_MAX = INT_W'(CONFIRM);
  localparam logic signed [CNT_W:0] HIT_LVL  = (CNT_W+1)'(THRESH);
  localparam logic signed [CNT_W:0] KEEP_LVL = (CNT_W+1)'(THRESH - HYST);
  localparam logic signed [CNT_W:0] POS_MAX  = (CNT_W+1)'((2**(CNT_W-1)) - 1);
  localparam logic signed [CNT_W:0] NEG_MIN  = -((CNT_W+1)'(2**(CNT_W-1)));

  logic [INT_W-1:0] integ_q;
  logic [INT_W-1:0] integ_inc;
  logic             hit;
  logic             keep;
  logic signed [CNT_W-1:0] diff_sat;

  assign hit       = (diff >= HIT_LVL);
  assign keep      = (diff >= KEEP_LVL);
  assign integ_inc = (integ_q == INT_MAX) ? integ_q : integ_q + 1'b1;

  always_comb begin
    if (diff > POS_MAX)      diff_sat = POS_MAX[CNT_W-1:0];
    else if (diff < NEG_MIN) diff_sat = NEG_MIN[CNT_W-1:0];
    else                     diff_sat = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q   <= 1'b0;
      integ_q <= '0;
      delta_q <= '0;
    end else if (recal_any) begin
      det_q   <= 1'b0;
      integ_q <= '0;
    end else if (smp_vld) begin
      if (cal_pend) begin
        delta_q <= '0;
        det_q   <= 1'b0;
        integ_q <= '0;
      end else begin
        delta_q <= diff_sat;
        if (det_q) begin
          if (!keep) begin
            det_q   <= 1'b0;
            integ_q <= '0;
          end
        end else if (hit) begin
          if (integ_inc == INT_MAX && !hold_in) begin
            det_q   <= 1'b1;
            integ_q <= '0;
          end else begin
            integ_q <= integ_inc;
          end
        end else begin
          integ_q <= '0;
        end
      end
    end
  end

  p_confirm_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(det_q) |-> ($past(integ_q) >= INT_W'(CONFIRM - 1)));

  p_run_reset_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !cal_pend && !recal_any && !det_q && !hit) |=> (integ_q == '0));

  p_hyst_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (det_q && smp_vld && !cal_pend && !recal_any && keep) |=> det_q);

  p_hold_block_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(det_q) |-> !$past(hold_in));

endmodule

// File: rtl/tcp_stuck_tmr.sv
module tcp_stuck_tmr #(
  parameter int SHORT_MS = 10000,
  parameter int LONG_MS  = 60000
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic det_q,
  input  logic no_limit,
  input  logic long_lim,
  output logic expire
);
  localparam int MAX_MS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int TW = $clog2(MAX_MS + 1);
  localparam logic [TW-1:0] SHORT_END = TW'(SHORT_MS - 1);
  localparam logic [TW-1:0] LONG_END  = TW'(LONG_MS - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] end_cnt;

  assign end_cnt = long_lim ? LONG_END : SHORT_END;
  assign expire  = ms_tick && det_q && !no_limit && (cnt_q >= end_cnt);

  always_ff @(posedge clk) begin
    if (rst || !det_q || expire) begin
      cnt_q <= '0;
    end else if (ms_tick && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !det_q |=> (cnt_q == '0));

endmodule

// File: rtl/tcp_out_drive.sv
module tcp_out_drive (
  input  logic clk,
  input  logic rst,
  input  logic det_q,
  input  logic dc_mode,
  input  logic drv_od,
  output logic key_out_q
);
  logic act_q;
  logic det_d_q;
  logic rise;
  logic act_n;

  assign rise = det_q && !det_d_q;

  always_comb begin
    if (dc_mode)   act_n = det_q;
    else if (rise) act_n = !act_q;
    else           act_n = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      det_d_q   <= 1'b0;
      key_out_q <= drv_od;
    end else begin
      act_q     <= act_n;
      det_d_q   <= det_q;
      key_out_q <= act_n ^ drv_od;
    end
  end

  p_dc_follow_r10: assert property (@(posedge clk) disable iff (rst)
    dc_mode |=> (act_q == $past(det_q)));

  p_toggle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!dc_mode && !rise) |=> $stable(act_q));

  p_toggle_flip_r11: assert property (@(posedge clk) disable iff (rst)
    (!dc_mode && rise) |=> (act_q != $past(act_q)));

endmodule

// File: rtl/touch_chan_proc.sv
module touch_chan_proc
  import tcp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int THRESH   = 6,
  parameter int HYST     = 2,
  parameter int CONFIRM  = 3,
  parameter int UP_MS    = 990,
  parameter int DN_MS    = 231,
  parameter int SHORT_MS = 10000,
  parameter int LONG_MS  = 60000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [CNT_W-1:0] smp_cnt,
  input  logic             ms_tick,
  input  logic             recal_req,
  input  logic [1:0]       tmo_sel,
  input  logic             drv_od,
  input  logic             hold_in,
  output logic             detected,
  output logic [CNT_W-1:0] delta,
  output logic             key_out
);
  localparam logic signed [CNT_W:0] HIT_LVL = (CNT_W+1)'(THRESH);

  tcp_cfg_t                cfg;
  logic [CNT_W-1:0]        ref_q;
  logic                    cal_pend;
  logic signed [CNT_W:0]   diff;
  logic                    det_q;
  logic signed [CNT_W-1:0] delta_q;
  logic                    expire;
  logic                    recal_any;
  logic                    freeze;

  assign cfg       = tcp_decode_sel(tmo_sel);
  assign diff      = $signed({1'b0, smp_cnt}) - $signed({1'b0, ref_q});
  assign recal_any = recal_req || expire;
  assign freeze    = det_q || (hold_in && diff >= HIT_LVL);

  tcp_ref_track #(.CNT_W(CNT_W), .UP_MS(UP_MS), .DN_MS(DN_MS)) u_ref (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_cnt(smp_cnt), .diff(diff),
    .ms_tick(ms_tick), .recal_any(recal_any), .freeze(freeze),
    .ref_q(ref_q), .cal_pend_q(cal_pend)
  );

  tcp_detect #(.CNT_W(CNT_W), .THRESH(THRESH), .HYST(HYST), .CONFIRM(CONFIRM)) u_det (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .cal_pend(cal_pend), .diff(diff),
    .hold_in(hold_in), .recal_any(recal_any), .det_q(det_q), .delta_q(delta_q)
  );

  tcp_stuck_tmr #(.SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)) u_tmr (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .det_q(det_q),
    .no_limit(cfg.no_limit), .long_lim(cfg.long_lim), .expire(expire)
  );

  tcp_out_drive u_out (
    .clk(clk), .rst(rst), .det_q(det_q), .dc_mode(cfg.dc_mode),
    .drv_od(drv_od), .key_out_q(key_out)
  );

  assign detected = det_q;
  assign delta    = delta_q;

  p_timeout_recal_r9: assert property (@(posedge clk) disable iff (rst)
    expire |=> (!det_q && cal_pend));

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!det_q && delta_q == '0));

endmodule

// File: tb/sim_touch_chan_proc.sv
`timescale 1ns/1ps
module sim_touch_chan_proc;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_vld = 1'b0;
  logic [W-1:0] smp_cnt = '0;
  logic         ms_tick = 1'b0;
  logic         recal_req = 1'b0;
  logic [1:0]   tmo_sel = 2'b00;
  logic         drv_od = 1'b0;
  logic         hold_in = 1'b0;
  logic         detected;
  logic [W-1:0] delta;
  logic         key_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  touch_chan_proc #(.CNT_W(W), .THRESH(6), .HYST(2), .CONFIRM(3),
    .UP_MS(8), .DN_MS(4), .SHORT_MS(30), .LONG_MS(60)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_cnt(smp_cnt),
    .ms_tick(ms_tick), .recal_req(recal_req), .tmo_sel(tmo_sel),
    .drv_od(drv_od), .hold_in(hold_in), .detected(detected),
    .delta(delta), .key_out(key_out));

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic send(input int v);
    @(negedge clk); smp_vld = 1'b1; smp_cnt = W'(v);
    @(negedge clk); smp_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic recal();
    @(negedge clk); recal_req = 1'b1;
    @(negedge clk); recal_req = 1'b0;
    @(negedge clk);
  endtask

  function automatic int sd(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic touch3(input int v);
    for (int k = 0; k < 3; k++) send(v);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit m_det;
    int m_int;
    repeat (3) @(negedge clk);
    check("R1 det", detected, 0);
    check("R1 delta", sd(delta), 0);
    check("R1 key_out", key_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 det after release", detected, 0);
    check("R1 key_out after release", key_out, 0);

    // R2 calibration
    send(100);
    check("R2 cal delta", sd(delta), 0);
    send(103);
    check("R2 delta", sd(delta), 3);

    // R3/R4 sweep of delta patterns, DC no limit
    m_det = 1'b0; m_int = 0;
    for (int i = 0; i < 66; i++) begin
      int dv;
      dv = (i * 7) % 11;
      send(100 + dv);
      if (!m_det) begin
        if (dv >= 6) begin
          m_int++;
          if (m_int >= 3) begin m_det = 1'b1; m_int = 0; end
        end else m_int = 0;
      end else if (dv < 4) begin
        m_det = 1'b0; m_int = 0;
      end
      check("R3 sweep delta", sd(delta), dv);
      check("R3 R4 sweep det", detected, int'(m_det));
      check("R10 sweep key_out", key_out, int'(m_det));
    end

    // R5 hold blocks confirmation, hits accumulate
    send(100);
    check("R4 release", detected, 0);
    hold_in = 1'b1;
    for (int k = 0; k < 3; k++) begin
      send(108);
      check("R5 held det", detected, 0);
    end
    hold_in = 1'b0;
    send(108);
    check("R5 confirm after hold", detected, 1);
    send(104);
    check("R4 keep at 4", detected, 1);
    send(103);
    check("R4 release at 3", detected, 0);

    // R6 upward drift
    recal(); send(100);
    ticks(7); send(102);
    check("R6 no early step", sd(delta), 2);
    ticks(1); send(102);
    check("R6 step sample", sd(delta), 2);
    send(102);
    check("R6 after step", sd(delta), 1);
    ticks(7); send(102);
    check("R6 age restarted", sd(delta), 1);
    ticks(1); send(102); send(102);
    check("R6 second step", sd(delta), 0);

    // R7 downward drift
    recal(); send(102);
    ticks(3); send(99);
    check("R7 no early step", sd(delta), -3);
    ticks(1); send(99); send(99);
    check("R7 after step", sd(delta), -2);

    // R8 freeze while detected and while held strong
    recal(); send(100); touch3(110);
    check("R8 det", detected, 1);
    ticks(20); send(110);
    check("R8 frozen detected", sd(delta), 10);
    recal(); send(100);
    hold_in = 1'b1;
    ticks(20); send(107); send(107);
    check("R8 frozen held", sd(delta), 7);
    check("R5 held no det", detected, 0);
    hold_in = 1'b0;

    // R9/R10 DC with short limit
    tmo_sel = 2'b01;
    recal(); send(100); touch3(110);
    check("R10 dc key on", key_out, 1);
    ticks(29);
    check("R9 short not yet", detected, 1);
    ticks(1);
    check("R9 short expired", detected, 0);
    check("R10 dc key off", key_out, 0);
    send(110);
    check("R9 recal delta", sd(delta), 0);
    touch3(110);
    check("R10 stays off", key_out, 0);
    check("R10 no redetect", detected, 0);

    // R9 long limit
    tmo_sel = 2'b10;
    recal(); send(100); touch3(110);
    ticks(31);
    check("R9 long past short", detected, 1);
    ticks(28);
    check("R9 long not yet", detected, 1);
    ticks(1);
    check("R9 long expired", detected, 0);

    // R9 no limit
    tmo_sel = 2'b00;
    recal(); send(100); touch3(110);
    ticks(100);
    check("R9 infinite", detected, 1);
    recal();
    check("R10 off after recal", key_out, 0);

    // R11 toggle
    tmo_sel = 2'b11;
    send(100); touch3(110);
    check("R11 first touch on", key_out, 1);
    send(100);
    check("R11 release keeps", key_out, 1);
    touch3(110);
    check("R11 second touch off", key_out, 0);
    send(100);
    touch3(110);
    check("R11 third touch on", key_out, 1);
    ticks(29);
    check("R9 toggle short not yet", detected, 1);
    ticks(1);
    check("R9 toggle expired", detected, 0);
    check("R11 timeout keeps", key_out, 1);

    // R12 polarity
    drv_od = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R12 open drain active", key_out, 0);
    drv_od = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 push pull active", key_out, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule